// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Supervisor

This block supervises an analog clock-recovery loop from the reference clock domain. It steers the loop with a single select line, either onto the reference (training) or onto the incoming serial data (tracking). It measures the frequency of a pre-divided copy of the recovered clock once per gate window and compares the count with a rate-dependent expected value. The loop is released to the data only after training has settled. A debounced lock flag is raised only after the loop has stayed inside the frequency window for several gates while tracking. Any out-of-window gate, or a loss indication from either of two active-low inputs, sends the loop back to training. This cycle repeats for as long as the data stays off frequency.

The block also owns the output-side muxing. During loss of signal in normal operation the serial data output is held at zero. In a bypass test setting the output clock becomes the inverted reference, and the data is retimed on the reference rising edge.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, `loop_sel_ref` is 1 (training) and `lock_o` is 0.
- R2: The loop is released to the data (`loop_sel_ref` falls) only at the end of a gate that measured in-window. At least TRAIN_N consecutive in-window training gates, each GATE_LEN reference cycles long, come first.
- R3: The expected count per gate is GATE_LEN*MULT_HI/PRE_DIV when `rate_hi`=1 and GATE_LEN*MULT_LO/PRE_DIV when `rate_hi`=0. The tolerance is expected/TOL_DIV counts, with inclusive bounds. A data frequency inside the window ends in lock; one outside it never does.
- R4: `lock_o` rises exactly DEB_N gate periods after the release to the data, provided every tracking gate is in-window. After that it stays high with no chatter while the frequency stays in the window.
- R5: A single out-of-window gate while tracking drops the lock and returns the loop to training. While the data remains off frequency, training and release repeat, and `lock_o` stays 0.
- R6: `lock_o` is 0 immediately whenever `sig_det` or `hold_ref_n` is 0. Within a few reference cycles the loop is back in training.
- R7: Loss of signal means `test_en`=0 with `sig_det`=0 or `hold_ref_n`=0. During it, `los_o`=1, `mute_o`=1 and `out_data`=0.
- R8: In bypass (`test_en`=1 and `rate_hi`=1), `out_clk` is the inverse of `ref_clk`, and `out_data` is `ser_din` as sampled on the latest `ref_clk` rising edge.
- R9: Outside bypass, `out_clk` follows `rec_clk`. When not muted, `out_data` follows `ser_din` directly.
- R10: With `test_en`=1, low loss inputs do not mute. `los_o`=0 and data passes, but the lock is still forced low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_clk | input | 1 | Pre-divided recovered clock from the loop |
| rate_hi | input | 1 | Rate select, 1 = higher rate (x32), 0 = lower rate (x8) |
| test_en | input | 1 | Test mode input |
| sig_det | input | 1 | Signal detect, active high (low = loss) |
| hold_ref_n | input | 1 | Hold-to-reference request, active low |
| ser_din | input | 1 | Serial data from the recovery loop |
| loop_sel_ref | output | 1 | 1 = steer loop to reference, 0 = track data |
| lock_o | output | 1 | Debounced frequency lock flag |
| los_o | output | 1 | Loss-of-signal flag |
| mute_o | output | 1 | Data mute enable |
| out_clk | output | 1 | Output clock (recovered or inverted reference) |
| out_data | output | 1 | Output serial data |

## Verification
On every reference cycle the assertions check four things. The lock and the release to the data change only on a gate result of the right kind. A return to training is always explained by a bad gate or a loss input. A raised lock never coexists with training, and a muted output is always zero. Only the bench scenarios can show the arithmetic window itself, the exact DEB_N-gate debounce delay, the endless retraining on an off-frequency input, and the bypass clock and retiming. The bench does this by sweeping the data period across both rates and comparing against counts computed from the clock ratio.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

  typedef enum logic [0:0] {
    ST_TRAIN = 1'b0,
    ST_TRACK = 1'b1
  } acq_st_e;

  // inclusive window test written without subtraction to avoid underflow
  function automatic logic in_window(input logic [31:0] val,
                                     input logic [31:0] center,
                                     input logic [31:0] tol);
    return ((val + tol) >= center) && (val <= (center + tol));
  endfunction

endpackage

// File: rtl/cdr_rst_sync.sv
module cdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/cdr_rate_meter.sv
module cdr_rate_meter
  import cdr_lock_pkg::*;
#(
  parameter int GATE_LEN = 8192,
  parameter int EXP_HI   = 16384,
  parameter int EXP_LO   = 4096,
  parameter int TOL_HI   = 8,
  parameter int TOL_LO   = 2,
  parameter int CNT_W    = 17
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic rec_clk,
  input  logic rec_rst_n,
  input  logic rate_hi,
  output logic gate_done,
  output logic win_ok
);
  localparam int GATE_W = (GATE_LEN > 1) ? $clog2(GATE_LEN) : 1;

  // recovered-clock domain: binary counter with registered Gray copy
  logic [CNT_W-1:0] rbin_q, rbin_d, rgray_q;

  always_comb rbin_d = rbin_q + CNT_W'(1);

  always_ff @(posedge rec_clk or negedge rec_rst_n) begin
    if (!rec_rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
    end
  end

  // reference domain: two-flop synchronizer on the Gray value
  logic [CNT_W-1:0] sync1_q, sync2_q, cur_bin;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= rgray_q;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    cur_bin[CNT_W-1] = sync2_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      cur_bin[i] = cur_bin[i+1] ^ sync2_q[i];
    end
  end

  // gate timer and per-gate decision
  logic [GATE_W-1:0] gcnt_q, gcnt_d;
  logic [CNT_W-1:0]  snap_q, snap_d, delta;
  logic              done_q, done_d, ok_q, ok_d;
  logic              gate_end;
  logic [31:0]       center, tol;

  always_comb begin
    gate_end = (gcnt_q == GATE_W'(GATE_LEN - 1));
    gcnt_d   = gate_end ? '0 : gcnt_q + GATE_W'(1);
    delta    = cur_bin - snap_q;
    center   = rate_hi ? 32'(EXP_HI) : 32'(EXP_LO);
    tol      = rate_hi ? 32'(TOL_HI) : 32'(TOL_LO);
    snap_d   = snap_q;
    ok_d     = ok_q;
    done_d   = 1'b0;
    if (gate_end) begin
      snap_d = cur_bin;
      ok_d   = in_window(32'(delta), center, tol);
      done_d = 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      gcnt_q <= '0;
      snap_q <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      gcnt_q <= gcnt_d;
      snap_q <= snap_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign gate_done = done_q;
  assign win_ok    = ok_q;
endmodule

// File: rtl/cdr_acq_fsm.sv
module cdr_acq_fsm
  import cdr_lock_pkg::*;
#(
  parameter int TRAIN_N = 2,
  parameter int DEB_N   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_done,
  input  logic win_ok,
  input  logic loss,
  output logic sel_ref,
  output logic lock
);
  localparam int TW = $clog2(TRAIN_N + 1);
  localparam int DW = $clog2(DEB_N + 1);

  acq_st_e       state_q, state_d;
  logic [TW-1:0] train_q, train_d;
  logic [DW-1:0] deb_q, deb_d;
  logic          lock_q, lock_d;

  always_comb begin
    state_d = state_q;
    train_d = train_q;
    deb_d   = deb_q;
    lock_d  = lock_q;
    if (loss) begin
      state_d = ST_TRAIN;
      train_d = '0;
      deb_d   = '0;
      lock_d  = 1'b0;
    end else if (gate_done) begin
      case (state_q)
        ST_TRAIN: begin
          if (!win_ok) begin
            train_d = '0;
          end else if (train_q == TW'(TRAIN_N - 1)) begin
            state_d = ST_TRACK;
            train_d = '0;
            deb_d   = '0;
          end else begin
            train_d = train_q + TW'(1);
          end
        end
        ST_TRACK: begin
          if (!win_ok) begin
            state_d = ST_TRAIN;
            lock_d  = 1'b0;
            deb_d   = '0;
            train_d = '0;
          end else if (deb_q == DW'(DEB_N - 1)) begin
            lock_d = 1'b1;
          end else begin
            deb_d = deb_q + DW'(1);
          end
        end
        default: state_d = ST_TRAIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TRAIN;
      train_q <= '0;
      deb_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      train_q <= train_d;
      deb_q   <= deb_d;
      lock_q  <= lock_d;
    end
  end

  assign sel_ref = (state_q == ST_TRAIN);
  assign lock    = lock_q;
endmodule

// File: rtl/cdr_out_path.sv
module cdr_out_path (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic rec_clk,
  input  logic ser_din,
  input  logic bypass,
  input  logic mute,
  output logic out_clk,
  output logic out_data
);
  logic din_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) din_q <= 1'b0;
    else            din_q <= ser_din;
  end

  always_comb begin
    out_clk  = bypass ? ~ref_clk : rec_clk;
    out_data = mute ? 1'b0 : (bypass ? din_q : ser_din);
  end
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
  parameter int GATE_LEN = 8192,
  parameter int MULT_HI  = 32,
  parameter int MULT_LO  = 8,
  parameter int PRE_DIV  = 16,
  parameter int TOL_DIV  = 2000,
  parameter int TRAIN_N  = 2,
  parameter int DEB_N    = 4
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rec_clk,
  input  logic rate_hi,
  input  logic test_en,
  input  logic sig_det,
  input  logic hold_ref_n,
  input  logic ser_din,
  output logic loop_sel_ref,
  output logic lock_o,
  output logic los_o,
  output logic mute_o,
  output logic out_clk,
  output logic out_data
);
  localparam int EXP_HI = GATE_LEN * MULT_HI / PRE_DIV;
  localparam int EXP_LO = GATE_LEN * MULT_LO / PRE_DIV;
  localparam int TOL_HI = EXP_HI / TOL_DIV;
  localparam int TOL_LO = EXP_LO / TOL_DIV;
  localparam int CNT_W  = $clog2(EXP_HI + TOL_HI + 1) + 2;

  logic ref_srst_n, rec_srst_n;
  logic gate_done, win_ok, lock_int;
  logic loss_raw, loss_m, loss_s;
  logic bypass, los;

  cdr_rst_sync #(.STAGES(2)) u_rst_ref (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_srst_n));
  cdr_rst_sync #(.STAGES(2)) u_rst_rec (
    .clk(rec_clk), .arst_n(rst_n), .srst_n(rec_srst_n));

  assign loss_raw = ~sig_det | ~hold_ref_n;

  always_ff @(posedge ref_clk or negedge ref_srst_n) begin
    if (!ref_srst_n) begin
      loss_m <= 1'b0;
      loss_s <= 1'b0;
    end else begin
      loss_m <= loss_raw;
      loss_s <= loss_m;
    end
  end

  cdr_rate_meter #(
    .GATE_LEN(GATE_LEN), .EXP_HI(EXP_HI), .EXP_LO(EXP_LO),
    .TOL_HI(TOL_HI), .TOL_LO(TOL_LO), .CNT_W(CNT_W)
  ) u_meter (
    .ref_clk(ref_clk), .ref_rst_n(ref_srst_n),
    .rec_clk(rec_clk), .rec_rst_n(rec_srst_n),
    .rate_hi(rate_hi), .gate_done(gate_done), .win_ok(win_ok));

  cdr_acq_fsm #(.TRAIN_N(TRAIN_N), .DEB_N(DEB_N)) u_fsm (
    .clk(ref_clk), .rst_n(ref_srst_n), .gate_done(gate_done),
    .win_ok(win_ok), .loss(loss_s), .sel_ref(loop_sel_ref), .lock(lock_int));

  assign bypass = test_en & rate_hi;
  assign los    = ~test_en & loss_raw;

  cdr_out_path u_out (
    .ref_clk(ref_clk), .ref_rst_n(ref_srst_n), .rec_clk(rec_clk),
    .ser_din(ser_din), .bypass(bypass), .mute(los),
    .out_clk(out_clk), .out_data(out_data));

  assign lock_o = lock_int & sig_det & hold_ref_n;
  assign los_o  = los;
  assign mute_o = los;
endmodule

// File: rtl/cdr_lock_ctrl_chk.sv
module cdr_lock_ctrl_chk (
  input logic ref_clk,
  input logic ref_srst_n,
  input logic gate_done,
  input logic win_ok,
  input logic loss_s,
  input logic lock_int,
  input logic loop_sel_ref,
  input logic mute_o,
  input logic out_data
);
  // R2
  release_chk: assert property (@(posedge ref_clk) disable iff (!ref_srst_n)
    $fell(loop_sel_ref) |-> $past(gate_done && win_ok && !loss_s));

  // R4
  lock_rise_chk: assert property (@(posedge ref_clk) disable iff (!ref_srst_n)
    $rose(lock_int) |-> ($past(gate_done && win_ok) && !loop_sel_ref));

  // R4
  lock_track_chk: assert property (@(posedge ref_clk) disable iff (!ref_srst_n)
    lock_int |-> !loop_sel_ref);

  // R5
  retrain_chk: assert property (@(posedge ref_clk) disable iff (!ref_srst_n)
    $rose(loop_sel_ref) |-> $past((gate_done && !win_ok) || loss_s));

  // R6
  loss_drop_chk: assert property (@(posedge ref_clk) disable iff (!ref_srst_n)
    loss_s |=> (loop_sel_ref && !lock_int));

  // R7
  mute_zero_chk: assert property (@(posedge ref_clk) disable iff (!ref_srst_n)
    mute_o |-> !out_data);
endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk u_chk (
  .ref_clk(ref_clk), .ref_srst_n(ref_srst_n), .gate_done(gate_done),
  .win_ok(win_ok), .loss_s(loss_s), .lock_int(lock_int),
  .loop_sel_ref(loop_sel_ref), .mute_o(mute_o), .out_data(out_data));

// File: tb/tb_cdr_lock_ctrl.sv
module tb_cdr_lock_ctrl;
  localparam int GATE    = 256;
  localparam int MHI     = 32;
  localparam int MLO     = 8;
  localparam int PDIV    = 16;
  localparam int TDIV    = 64;
  localparam int TRN     = 2;
  localparam int DEB     = 4;
  localparam int REF_PER = 5000;

  localparam int EHI = GATE * MHI / PDIV;
  localparam int ELO = GATE * MLO / PDIV;
  localparam int NOM_HI = GATE * REF_PER / EHI;
  localparam int NOM_LO = GATE * REF_PER / ELO;

  logic ref_clk, rst_n, rec_clk, rate_hi, test_en, sig_det, hold_ref_n, ser_din;
  logic loop_sel_ref, lock_o, los_o, mute_o, out_clk, out_data;
  int   data_per;
  int   total, bad;

  cdr_lock_ctrl #(.GATE_LEN(GATE), .MULT_HI(MHI), .MULT_LO(MLO), .PRE_DIV(PDIV),
                  .TOL_DIV(TDIV), .TRAIN_N(TRN), .DEB_N(DEB)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .rec_clk(rec_clk), .rate_hi(rate_hi),
    .test_en(test_en), .sig_det(sig_det), .hold_ref_n(hold_ref_n),
    .ser_din(ser_din), .loop_sel_ref(loop_sel_ref), .lock_o(lock_o),
    .los_o(los_o), .mute_o(mute_o), .out_clk(out_clk), .out_data(out_data));

  initial begin
    ref_clk = 1'b0;
    forever #(REF_PER / 2) ref_clk = ~ref_clk;
  end

  // loop model: nominal frequency while training, data frequency while tracking
  initial begin
    rec_clk = 1'b0;
    forever begin
      int p;
      p = (loop_sel_ref !== 1'b0) ? (rate_hi ? NOM_HI : NOM_LO) : data_per;
      #(p / 2) rec_clk = ~rec_clk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst_n = 1'b0;
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_gates(input int n);
    repeat (n * GATE) @(negedge ref_clk);
  endtask

  // R3 / R5: one point of the period sweep
  task automatic sweep_point(input logic hi, input int per);
    real c, d;
    int  expv, tol, lk, falls;
    logic prev;
    expv = hi ? EHI : ELO;
    tol  = expv / TDIV;
    c    = real'(GATE) * real'(REF_PER) / real'(per);
    d    = (c > expv) ? c - expv : expv - c;
    if (((d > tol) ? d - tol : tol - d) < 1.5) return;
    rate_hi  = hi;
    data_per = per;
    do_reset();
    lk = 0; falls = 0; prev = 1'b1;
    repeat (12 * GATE) begin
      @(negedge ref_clk);
      if (lock_o) lk = 1;
      if (prev && !loop_sel_ref) falls++;
      prev = loop_sel_ref;
    end
    if (d <= tol) begin
      chk($sformatf("R3 lock hi=%0d per=%0d", hi, per), int'(lock_o), 1);
      chk($sformatf("R3 tracking hi=%0d per=%0d", hi, per), int'(loop_sel_ref), 0);
    end else begin
      chk($sformatf("R3 no lock hi=%0d per=%0d", hi, per), lk, 0);
      chk($sformatf("R5 retrain repeats hi=%0d per=%0d", hi, per), int'(falls >= 2), 1);
    end
  endtask

  initial begin
    #(64'd1_000_000_000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t_rel, t_lock, lk_lo, falls;
    logic prev;
    total = 0; bad = 0;
    rst_n = 1'b0; rate_hi = 1'b1; test_en = 1'b0; sig_det = 1'b1;
    hold_ref_n = 1'b1; ser_din = 1'b0; data_per = NOM_HI;
    repeat (3) @(negedge ref_clk);
    // R1 reset state
    chk("R1 sel during reset", int'(loop_sel_ref), 1);
    chk("R1 lock during reset", int'(lock_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);
    chk("R1 sel after reset", int'(loop_sel_ref), 1);
    chk("R1 lock after reset", int'(lock_o), 0);

    // R2 / R4: release timing and exact debounce delay
    do_reset();
    t_rel = 0;
    while (loop_sel_ref && t_rel < 20 * GATE) begin
      @(negedge ref_clk);
      t_rel++;
    end
    chk("R2 training lasts TRAIN_N gates", int'(t_rel >= TRN * GATE && t_rel < 20 * GATE), 1);
    t_lock = 0;
    while (!lock_o && t_lock < 20 * GATE) begin
      @(negedge ref_clk);
      t_lock++;
    end
    chk("R4 debounce delay", t_lock, DEB * GATE);
    lk_lo = 0;
    repeat (4 * GATE) begin
      @(negedge ref_clk);
      if (!lock_o) lk_lo++;
    end
    chk("R4 lock steady", lk_lo, 0);

    // R5: frequency leaves the window while locked
    data_per = 2700;
    wait_gates(2);
    chk("R5 lock dropped", int'(lock_o), 0);
    lk_lo = 0; falls = 0; prev = loop_sel_ref;
    repeat (9 * GATE) begin
      @(negedge ref_clk);
      if (lock_o) lk_lo++;
      if (prev && !loop_sel_ref) falls++;
      prev = loop_sel_ref;
    end
    chk("R5 lock stays low", lk_lo, 0);
    chk("R5 training repeats", int'(falls >= 2), 1);

    // R6: loss inputs force lock low
    data_per = NOM_HI;
    wait_gates(12);
    chk("R6 relocked", int'(lock_o), 1);
    sig_det = 1'b0;
    #100;
    chk("R6 lock low on sig_det", int'(lock_o), 0);
    chk("R7 los on sig_det", int'(los_o), 1);
    repeat (4) @(negedge ref_clk);
    chk("R6 back to training", int'(loop_sel_ref), 1);
    sig_det = 1'b1;
    wait_gates(12);
    chk("R6 relocked after sig_det", int'(lock_o), 1);
    hold_ref_n = 1'b0;
    #100;
    chk("R6 lock low on hold_ref_n", int'(lock_o), 0);
    repeat (4) @(negedge ref_clk);
    chk("R6 training on hold_ref_n", int'(loop_sel_ref), 1);
    hold_ref_n = 1'b1;

    // R7 / R9: mute and pass-through
    @(negedge ref_clk);
    ser_din = 1'b1; sig_det = 1'b0;
    #100;
    chk("R7 mute sig_det", int'(mute_o), 1);
    chk("R7 data zero sig_det", int'(out_data), 0);
    sig_det = 1'b1; hold_ref_n = 1'b0;
    #100;
    chk("R7 los hold_ref_n", int'(los_o), 1);
    chk("R7 data zero hold_ref_n", int'(out_data), 0);
    hold_ref_n = 1'b1;
    #100;
    chk("R7 los clear", int'(los_o), 0);
    chk("R9 data passes 1", int'(out_data), 1);
    ser_din = 1'b0;
    #100;
    chk("R9 data passes 0", int'(out_data), 0);
    for (int i = 0; i < 20; i++) begin
      #(137 + i * 91);
      chk("R9 out_clk follows rec_clk", int'(out_clk), int'(rec_clk));
    end

    // R8: bypass
    test_en = 1'b1; rate_hi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(posedge ref_clk); #100;
      chk("R8 out_clk inverted high", int'(out_clk), 0);
      @(negedge ref_clk); #100;
      chk("R8 out_clk inverted low", int'(out_clk), 1);
    end
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = logic'((16'hB4D2 >> i) & 16'h1);
      @(negedge ref_clk);
      ser_din = b;
      @(posedge ref_clk);
      #100 ser_din = ~b;
      #100;
      chk("R8 retimed data", int'(out_data), int'(b));
    end

    // R10: test high blocks mute in the disallowed low-rate setting
    rate_hi = 1'b0; sig_det = 1'b0;
    @(negedge ref_clk);
    ser_din = 1'b1;
    #100;
    chk("R10 no los", int'(los_o), 0);
    chk("R10 data passes", int'(out_data), 1);
    chk("R10 lock forced low", int'(lock_o), 0);
    sig_det = 1'b1; test_en = 1'b0; ser_din = 1'b0;

    // R3 / R5: period sweeps at both rates
    for (int p = 2400; p <= 2600; p += 20) sweep_point(1'b1, p);
    for (int p = 9600; p <= 10400; p += 100) sweep_point(1'b0, p);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule